// File: doc/BRIEF.md
# Glitch-free clock output enable

This block decides whether one buffered copy of a reference clock is driven out of the chip or left floating. Two active-low disable sources feed it: an enable pin at the package edge and an enable bit held in a configuration register. The output runs only when both of them ask for it. If either one, or both, withdraws permission, the output stops and the pad goes to high impedance.

Both enable sources may change at any moment, with no relation to the clock. Their combined request is therefore brought into the clock domain through a chain of rising-edge flops. The resulting decision is applied by a gate flop that updates on the falling edge. Because of this, the output can only start or stop while the clock is low. Every high pulse that reaches the pin has the full high-phase width of the reference clock.

Starting and stopping both settle within a bounded window of clock periods. The same gate drives the pad's drive-enable flag, so the pad is released at the same instant the clock is parked low.

Top module: `gated_clk_oe`

## Requirements
- R1: With the default three-stage synchronizer, once `en_pin` AND `en_reg` has been 0 at three consecutive rising edges of `ref_clk`, `drv_en` is 0 and `clk_out` stays low. A 0 on either input alone, or on both, is enough to disable the output.
- R2: Once `en_pin` AND `en_reg` has been 1 at three consecutive rising edges, `drv_en` is 1 and `clk_out` follows `ref_clk`. A change of either input that lies entirely between two rising edges has no effect on the output.
- R3: `clk_out` is 0 whenever `ref_clk` is low, and `clk_out` is 0 whenever `drv_en` is 0.
- R4: `drv_en` changes only at a falling edge of `ref_clk`, never while `ref_clk` is high.
- R5: Every high pulse on `clk_out` begins at a rising edge of `ref_clk` and lasts exactly half a clock period.
- R6: After the combined enable becomes true, `drv_en` rises no sooner than 2 and no later than 6 clock periods later (with three stages, 2.5 to 3.5 periods).
- R7: After the combined enable becomes false, `drv_en` falls no sooner than 2 and no later than 6 clock periods later.
- R8: `rst_n` is synchronous and active low. While it is low, `drv_en` and `clk_out` are 0 from the following edge on. After release, the output stays off until the enable has been sampled afresh and has passed through every synchronizer stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock to be buffered |
| rst_n | input | 1 | Synchronous reset, active low |
| en_pin | input | 1 | Asynchronous enable pin, 0 disables the output |
| en_reg | input | 1 | Register enable bit, 0 disables the output |
| clk_out | output | 1 | Gated copy of `ref_clk`, low while disabled |
| drv_en | output | 1 | Drive enable for the tri-state pad, 0 means high impedance |

## Verification
The checker's run counters assume that each enable input holds one settled value at every rising edge. They also assume that reset is asserted from time zero and driven in step with the clock. The stimulus respects both assumptions. It moves the enable inputs at varied offsets inside the clock period, in both the high phase and the low phase, but never on either edge. It changes `rst_n` just after a rising edge. A short disable pulse placed between two rising edges shows that a request the synchronizer never samples leaves the output untouched.

// File: rtl/gated_clk_oe_pkg.sv
package gated_clk_oe_pkg;

    localparam int unsigned SYNC_STAGES_DEFAULT = 3;

    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_mode_e;

    typedef struct packed {
        gate_mode_e mode;
    } gate_state_t;

    function automatic logic combine_enables(input logic pin_en, input logic reg_en);
        return pin_en & reg_en;
    endfunction

    function automatic gate_mode_e mode_of(input logic run_req);
        return run_req ? GATE_RUNNING : GATE_PARKED;
    endfunction

endpackage

// File: rtl/gated_clk_oe_sync.sv
module gated_clk_oe_sync #(
    parameter int unsigned STAGES = gated_clk_oe_pkg::SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/gated_clk_oe_gate.sv
module gated_clk_oe_gate
    import gated_clk_oe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic clk_gated,
    output logic drive_on
);
    gate_state_t state;

    // Updated only at the falling edge, so the gate changes while clk is low.
    always_ff @(negedge clk) begin
        if (!rst_n) state.mode <= GATE_PARKED;
        else        state.mode <= mode_of(run_req);
    end

    assign drive_on  = (state.mode == GATE_RUNNING);
    assign clk_gated = clk & drive_on;
endmodule

// File: rtl/gated_clk_oe.sv
module gated_clk_oe #(
    parameter int unsigned SYNC_STAGES = gated_clk_oe_pkg::SYNC_STAGES_DEFAULT
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic en_reg,
    output logic clk_out,
    output logic drv_en
);
    import gated_clk_oe_pkg::*;

    logic want_async;
    logic want_sync;

    assign want_async = combine_enables(en_pin, en_reg);

    gated_clk_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .d_async (want_async),
        .q_sync  (want_sync)
    );

    gated_clk_oe_gate u_gate (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .run_req   (want_sync),
        .clk_gated (clk_out),
        .drive_on  (drv_en)
    );
endmodule

// File: rtl/gated_clk_oe_chk.sv
module gated_clk_oe_chk #(
    parameter int unsigned SYNC_STAGES = 3
) (
    input logic ref_clk,
    input logic rst_n,
    input logic en_pin,
    input logic en_reg,
    input logic clk_out,
    input logic drv_en
);
    localparam int unsigned RUN_CAP = 1000;

    logic        want;
    int unsigned on_run;
    int unsigned off_run;

    assign want = en_pin & en_reg;

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            on_run  <= 0;
            off_run <= 0;
        end else begin
            on_run  <= want  ? ((on_run  < RUN_CAP) ? on_run  + 1 : on_run)  : 0;
            off_run <= !want ? ((off_run < RUN_CAP) ? off_run + 1 : off_run) : 0;
        end
    end

    AST_STOPPED_AFTER_OFF_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n) (off_run >= SYNC_STAGES) |-> !drv_en); // R1
    AST_RUNNING_AFTER_ON_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n) (on_run >= SYNC_STAGES) |-> drv_en); // R2
    AST_LOW_AT_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n) !clk_out); // R3
    AST_PARKED_IN_RESET: assert property (@(posedge ref_clk) !rst_n |=> !drv_en); // R8

    always @(drv_en) begin
        if (!$isunknown(drv_en) && !$isunknown(ref_clk))
            AST_DRIVE_EDGE_WHILE_LOW: assert (ref_clk == 1'b0); // R4
    end
endmodule

bind gated_clk_oe gated_clk_oe_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .en_pin  (en_pin),
    .en_reg  (en_reg),
    .clk_out (clk_out),
    .drv_en  (drv_en)
);

// File: tb/tb_gated_clk_oe.sv
module tb_gated_clk_oe;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic en_pin  = 1'b0;
    logic en_reg  = 1'b0;
    logic clk_out;
    logic drv_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    logic hist[$];
    logic exp_gate = 1'b0;
    longint t_out_rise = 0;

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    gated_clk_oe #(.SYNC_STAGES(STAGES)) dut (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .en_pin  (en_pin),
        .en_reg  (en_reg),
        .clk_out (clk_out),
        .drv_en  (drv_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference model: history of sampled requests, gate decided at the falling edge.
    always @(posedge ref_clk) begin
        hist.push_back(rst_n ? (en_pin & en_reg) : 1'b0);
        if (hist.size() > 16) void'(hist.pop_front());
    end

    always @(negedge ref_clk) begin
        if (!rst_n || hist.size() < STAGES) exp_gate = 1'b0;
        else                                exp_gate = hist[hist.size() - STAGES];
    end

    always @(posedge ref_clk) begin
        if (cmp_on) begin
            #(CLK_PERIOD/4);
            chk("R1/R2 drv_en vs model", drv_en, exp_gate);
            chk("R1/R2 clk_out high phase vs model", clk_out, exp_gate);
        end
    end

    always @(negedge ref_clk) begin
        if (cmp_on) begin
            #(CLK_PERIOD/4);
            chk("R3 clk_out in low phase", clk_out, 1'b0);
        end
    end

    always @(posedge clk_out) begin
        if (cmp_on) begin
            t_out_rise = $time;
            chk_int("R5 rise aligned to ref edge", $time % CLK_PERIOD, CLK_PERIOD/2);
        end
    end

    always @(negedge clk_out) begin
        if (cmp_on) chk_int("R5 high pulse width", $time - t_out_rise, CLK_PERIOD/2);
    end

    task automatic await_drive(input logic target, input longint t0, input string req);
        bit     seen  = 1'b0;
        longint t_hit = 0;
        longint lat10;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge ref_clk);
            #1;
            if (drv_en === target) begin
                seen  = 1'b1;
                t_hit = $time - 1;
            end
        end
        n_cmp++;
        if (!seen) begin
            n_bad++;
            $display("FAIL %s: actual no change of drv_en expected %b within 6 periods", req, target);
        end else begin
            lat10 = ((t_hit - t0) * 10) / CLK_PERIOD;
            if (lat10 < 20 || lat10 > 60) begin
                n_bad++;
                $display("FAIL %s: actual latency %0d tenths expected 20..60 tenths", req, lat10);
            end
        end
    endtask

    task automatic drive_and_measure(input logic pin, input logic regb, input int offset, input string req);
        longint t0;
        @(posedge ref_clk);
        #(offset);
        en_pin = pin;
        en_reg = regb;
        t0 = $time;
        await_drive(pin & regb, t0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual run still going expected finished");
        report();
    end

    initial begin
        longint t_rel;
        int     off;
        rst_n  = 1'b0;
        en_pin = 1'b1;
        en_reg = 1'b1;
        repeat (3) @(posedge ref_clk);
        #2;
        chk("R8 drv_en held in reset", drv_en, 1'b0);
        chk("R8 clk_out held in reset", clk_out, 1'b0);
        cmp_on = 1'b1;
        @(posedge ref_clk);
        #2;
        rst_n = 1'b1;
        t_rel = $time;
        @(posedge ref_clk); #4;
        chk("R8 still off first cycle after release", drv_en, 1'b0);
        @(posedge ref_clk); #4;
        chk("R8 still off second cycle after release", drv_en, 1'b0);
        await_drive(1'b1, t_rel, "R6 enable after reset release");

        drive_and_measure(1'b0, 1'b1, 3, "R7 pin low disables");
        drive_and_measure(1'b1, 1'b1, 7, "R6 pin high enables");
        drive_and_measure(1'b1, 1'b0, 1, "R7 register bit low disables");

        @(posedge ref_clk); #6;
        en_pin = 1'b0;
        repeat (6) @(posedge ref_clk);
        #4;
        chk("R1 both sources low keep output off", drv_en, 1'b0);
        #2;
        en_pin = 1'b1;
        repeat (8) @(posedge ref_clk);
        #4;
        chk("R1 register bit alone keeps output off", drv_en, 1'b0);

        drive_and_measure(1'b1, 1'b1, 8, "R6 register bit high enables");

        // Disable pulse lying wholly between two rising edges is never sampled.
        @(posedge ref_clk); #1;
        en_pin = 1'b0;
        #7;
        en_pin = 1'b1;
        repeat (6) begin
            @(posedge ref_clk); #4;
            chk("R2 unsampled pulse ignored", drv_en, 1'b1);
        end

        drive_and_measure(1'b0, 1'b0, 9, "R7 both sources drop together");
        drive_and_measure(1'b1, 1'b1, 2, "R6 both sources rise together");

        for (int c = 0; c < 400; c++) begin
            @(posedge ref_clk);
            off = 1 + ($urandom % 4) + ((($urandom % 2) == 1) ? 5 : 0);
            #(off);
            if (($urandom % 5) == 0) en_pin = ~en_pin;
            if (($urandom % 7) == 0) en_reg = ~en_reg;
        end

        repeat (8) @(posedge ref_clk);
        #1;
        cmp_on = 1'b0;
        report();
    end
endmodule